// File: doc/BRIEF.md
# AUX Request Header Packer

This block turns one request on a DisplayPort AUX channel into the byte stream that an AUX channel engine transmits, and turns the status byte that the engine returns into a reply code and a result. A request consists of a 20-bit address, a 4-bit command, a payload length and a payload buffer. One cycle after the request strobe, the block presents a frame. The frame holds a four-byte header followed by any write payload, together with the number of bytes to transmit. It also raises two error flags, one for a length outside the limits and one for an unknown command.

When the engine finishes, it hands back a status byte, the number of bytes it received, and the size of the requester's buffer. One cycle later the block reports one of three results. The first is a failure class: timeout, non-zero flags or error. The second, for a write, is the write length it accepted. The third, for a read, is the received count clamped to the buffer size. Any result that is not a failure also carries the reply code taken from the upper nibble of the status.

Top module: `aux_req_packer`

## Requirements
- R1: Frame byte 0 carries address bits 7:0 and frame byte 1 carries address bits 15:8.
- R2: Frame byte 2 carries the command in bits 7:4 and address bits 19:16 in bits 3:0. The command is copied unchanged, including bit 2.
- R3: Bits 3:0 of frame byte 3 hold the length minus one, or 0 for a zero length.
- R4: Bits 7:4 of frame byte 3 depend on the request. For a zero length they hold 3. For a read with a non-zero length they hold 4. For a write with a non-zero length they hold 4 plus the length, modulo 16, so a 12-byte write gives 0.
- R5: The transmit count is 4 plus the length for a write and 4 for a read. Frame byte i sits at tx_data bits 8i+7:8i. Write payload byte k is placed at frame byte 4+k for every k below the length, and every other frame byte is zero.
- R6: A length above 16 raises tx_err_len, whatever the command. In that case tx_count and tx_data are zero.
- R7: A write longer than 12 bytes raises tx_err_len and emits nothing. A read of up to 16 bytes is accepted.
- R8: Bit 2 of the command (the middle-of-transaction flag) is masked before the request is classified. After masking, 0x0 and 0x8 are writes and 0x1 and 0x9 are reads. Any other command with a legal length raises tx_err_cmd, and tx_count and tx_data are zero. The two error flags are never raised together.
- R9: After reset, tx_valid, rep_valid, tx_count and rep_len are 0. tx_valid is high for exactly the one cycle after a cycle with req_valid high.
- R10: A status of 1, 2 or 3 raises rep_timeout, rep_flags or rep_error respectively, exactly one of them. In that case rep_code and rep_len are 0.
- R11: For any other status, rep_code equals status bits 7:4 and no failure flag is raised.
- R12: On a successful reply after an accepted read, rep_len is the smaller of rsp_rx_len and rsp_buf_size.
- R13: On a successful reply after an accepted write, rep_len is that write's payload length. A rejected request leaves the remembered kind and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 20 | Request address |
| req_cmd | input | 4 | Request command, bit 2 = middle-of-transaction |
| req_len | input | 6 | Payload length in bytes |
| req_payload | input | 128 | Payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Frame outputs updated this cycle |
| tx_data | output | 160 | Header and payload bytes, byte i at bits 8i+7:8i |
| tx_count | output | 5 | Bytes to transmit |
| tx_err_len | output | 1 | Length limit exceeded |
| tx_err_cmd | output | 1 | Unknown command |
| rsp_valid | input | 1 | Engine status strobe |
| rsp_status | input | 8 | Engine status byte |
| rsp_rx_len | input | 5 | Bytes received by the engine |
| rsp_buf_size | input | 5 | Requester buffer size |
| rep_valid | output | 1 | Reply outputs updated this cycle |
| rep_code | output | 4 | Reply code |
| rep_timeout | output | 1 | Status was timeout |
| rep_flags | output | 1 | Status was flags not zero |
| rep_error | output | 1 | Status was error |
| rep_len | output | 5 | Result length |

## Verification
Directed requests cover the cases where header fields are easy to confuse. The zero-length request must give a count nibble of 3 against 4. The 12-byte write exposes the wrap of the count nibble. The 13-byte write is rejected while a 16-byte read is accepted, and a 17-byte request is rejected whatever its kind. Commands with bit 2 set must be classified like their base codes, while codes such as 0x2 and 0xA must be refused. Random requests over every command and lengths up to 20 check that write payload lands in the right byte lanes and that stale buffer bytes never leak past the length. Replies alternate between write and read history, with every failure status, plain codes, and received counts both above and below the buffer size, so the clamp and the remembered write length are told apart.

// File: rtl/aux_pack_pkg.sv
package aux_pack_pkg;

   typedef enum logic [1:0] {
      KIND_WRITE   = 2'd0,
      KIND_READ    = 2'd1,
      KIND_BAD_LEN = 2'd2,
      KIND_BAD_CMD = 2'd3
   } req_kind_e;

   localparam int          HDR_BYTES     = 4;
   localparam logic [3:0]  CMD_NATIVE_WR = 4'h8;
   localparam logic [3:0]  CMD_NATIVE_RD = 4'h9;
   localparam logic [3:0]  CMD_I2C_WR    = 4'h0;
   localparam logic [3:0]  CMD_I2C_RD    = 4'h1;
   localparam logic [3:0]  CMD_MOT_BIT   = 4'h4;

   localparam logic [7:0]  ST_TIMEOUT    = 8'd1;
   localparam logic [7:0]  ST_FLAGS      = 8'd2;
   localparam logic [7:0]  ST_ERROR      = 8'd3;

endpackage

// File: rtl/aux_req_classify.sv
module aux_req_classify
   import aux_pack_pkg::*;
#(
   parameter int LEN_W          = 6,
   parameter int MAX_PAYLOAD    = 16,
   parameter int MAX_WR_PAYLOAD = 12
) (
   input  logic [3:0]       cmd,
   input  logic [LEN_W-1:0] len,
   output req_kind_e        kind
);

   logic [3:0] base_cmd;
   logic       is_wr;
   logic       is_rd;
   logic       over_any;
   logic       over_wr;

   assign base_cmd = cmd & ~CMD_MOT_BIT;

   always_comb begin
      is_wr    = (base_cmd == CMD_NATIVE_WR) || (base_cmd == CMD_I2C_WR);
      is_rd    = (base_cmd == CMD_NATIVE_RD) || (base_cmd == CMD_I2C_RD);
      over_any = len > LEN_W'(MAX_PAYLOAD);
      over_wr  = len > LEN_W'(MAX_WR_PAYLOAD);
      if (over_any || (is_wr && over_wr))
         kind = KIND_BAD_LEN;
      else if (!is_wr && !is_rd)
         kind = KIND_BAD_CMD;
      else if (is_wr)
         kind = KIND_WRITE;
      else
         kind = KIND_READ;
   end

endmodule

// File: rtl/aux_hdr_format.sv
module aux_hdr_format
   import aux_pack_pkg::*;
#(
   parameter int LEN_W = 6,
   parameter int CNT_W = 5
) (
   input  logic [19:0]          addr,
   input  logic [3:0]           cmd,
   input  logic [LEN_W-1:0]     len,
   input  logic                 is_write,
   output logic [8*HDR_BYTES-1:0] hdr,
   output logic [CNT_W-1:0]     count
);

   localparam int TOT_W = LEN_W + 1;

   logic [TOT_W-1:0] total;
   logic [3:0]       len_nib;
   logic [3:0]       cnt_nib;

   always_comb begin
      total   = is_write ? (TOT_W'(len) + TOT_W'(HDR_BYTES)) : TOT_W'(HDR_BYTES);
      len_nib = (len == '0) ? 4'd0 : 4'(len - LEN_W'(1));
      cnt_nib = (len == '0) ? 4'(HDR_BYTES - 1) : total[3:0];
      hdr     = {cnt_nib, len_nib, cmd, addr[19:16], addr[15:8], addr[7:0]};
      count   = CNT_W'(total);
   end

endmodule

// File: rtl/aux_frame_assemble.sv
module aux_frame_assemble
   import aux_pack_pkg::*;
#(
   parameter int LEN_W       = 6,
   parameter int MAX_PAYLOAD = 16,
   parameter int FRAME_W     = 8 * (HDR_BYTES + MAX_PAYLOAD)
) (
   input  logic [8*HDR_BYTES-1:0]   hdr,
   input  logic [8*MAX_PAYLOAD-1:0] payload,
   input  logic [LEN_W-1:0]         len,
   input  logic                     emit,
   input  logic                     keep_payload,
   output logic [FRAME_W-1:0]       frame
);

   assign frame[8*HDR_BYTES-1:0] = emit ? hdr : '0;

   for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_lane
      assign frame[8*(HDR_BYTES+g) +: 8] =
         (keep_payload && (LEN_W'(g) < len)) ? payload[8*g +: 8] : 8'h00;
   end

endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
   import aux_pack_pkg::*;
#(
   parameter int RX_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_valid,
   input  logic            cap_write,
   input  logic [RX_W-1:0] cap_len,
   input  logic            rsp_valid,
   input  logic [7:0]      rsp_status,
   input  logic [RX_W-1:0] rsp_rx_len,
   input  logic [RX_W-1:0] rsp_buf_size,
   output logic            rep_valid,
   output logic [3:0]      rep_code,
   output logic            rep_timeout,
   output logic            rep_flags,
   output logic            rep_error,
   output logic [RX_W-1:0] rep_len
);

   logic            kind_wr_q;
   logic [RX_W-1:0] wr_len_q;
   logic            st_to;
   logic            st_fl;
   logic            st_er;
   logic            st_fail;
   logic [RX_W-1:0] clamp_len;
   logic [RX_W-1:0] len_n;
   logic [3:0]      code_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_wr_q <= 1'b0;
         wr_len_q  <= '0;
      end else if (cap_valid) begin
         kind_wr_q <= cap_write;
         wr_len_q  <= cap_len;
      end
   end

   always_comb begin
      st_to     = rsp_status == ST_TIMEOUT;
      st_fl     = rsp_status == ST_FLAGS;
      st_er     = rsp_status == ST_ERROR;
      st_fail   = st_to || st_fl || st_er;
      clamp_len = (rsp_rx_len > rsp_buf_size) ? rsp_buf_size : rsp_rx_len;
      len_n     = st_fail ? '0 : (kind_wr_q ? wr_len_q : clamp_len);
      code_n    = st_fail ? 4'd0 : rsp_status[7:4];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rep_valid   <= 1'b0;
         rep_code    <= '0;
         rep_timeout <= 1'b0;
         rep_flags   <= 1'b0;
         rep_error   <= 1'b0;
         rep_len     <= '0;
      end else begin
         rep_valid <= rsp_valid;
         if (rsp_valid) begin
            rep_code    <= code_n;
            rep_timeout <= st_to;
            rep_flags   <= st_fl;
            rep_error   <= st_er;
            rep_len     <= len_n;
         end
      end
   end

   // R10: failure classes are exclusive
   p_fail_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |-> $onehot0({rep_timeout, rep_flags, rep_error}));

   // R10: a failed reply carries no length and no code
   p_fail_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && (rep_timeout || rep_flags || rep_error)) |-> (rep_len == '0 && rep_code == '0));

   // R12: a read result never exceeds the buffer
   p_read_clamp_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && !$past(kind_wr_q)) |-> (rep_len <= $past(rsp_buf_size)));

   // R11: a successful reply follows the status upper nibble
   p_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_valid && !(rep_timeout || rep_flags || rep_error)) |-> (rep_code == $past(rsp_status[7:4])));

endmodule

// File: rtl/aux_req_packer.sv
module aux_req_packer
   import aux_pack_pkg::*;
#(
   parameter int MAX_PAYLOAD    = 16,
   parameter int MAX_WR_PAYLOAD = 12,
   localparam int LEN_W   = $clog2(MAX_PAYLOAD + 1) + 1,
   localparam int RX_W    = $clog2(MAX_PAYLOAD + 1),
   localparam int CNT_W   = $clog2(HDR_BYTES + MAX_PAYLOAD + 1),
   localparam int FRAME_W = 8 * (HDR_BYTES + MAX_PAYLOAD)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [19:0]              req_addr,
   input  logic [3:0]               req_cmd,
   input  logic [LEN_W-1:0]         req_len,
   input  logic [8*MAX_PAYLOAD-1:0] req_payload,
   output logic                     tx_valid,
   output logic [FRAME_W-1:0]       tx_data,
   output logic [CNT_W-1:0]         tx_count,
   output logic                     tx_err_len,
   output logic                     tx_err_cmd,
   input  logic                     rsp_valid,
   input  logic [7:0]               rsp_status,
   input  logic [RX_W-1:0]          rsp_rx_len,
   input  logic [RX_W-1:0]          rsp_buf_size,
   output logic                     rep_valid,
   output logic [3:0]               rep_code,
   output logic                     rep_timeout,
   output logic                     rep_flags,
   output logic                     rep_error,
   output logic [RX_W-1:0]          rep_len
);

   if (MAX_PAYLOAD > 16 || MAX_PAYLOAD < 1) begin : g_bad_max
      initial $fatal(1, "MAX_PAYLOAD must lie in 1..16 to fit the length nibble");
   end
   if (MAX_WR_PAYLOAD > MAX_PAYLOAD || MAX_WR_PAYLOAD < 1) begin : g_bad_wr
      initial $fatal(1, "MAX_WR_PAYLOAD must lie in 1..MAX_PAYLOAD");
   end

   req_kind_e              kind;
   logic                   is_write;
   logic                   accept;
   logic [8*HDR_BYTES-1:0] hdr;
   logic [CNT_W-1:0]       count;
   logic [FRAME_W-1:0]     frame;

   aux_req_classify #(
      .LEN_W          (LEN_W),
      .MAX_PAYLOAD    (MAX_PAYLOAD),
      .MAX_WR_PAYLOAD (MAX_WR_PAYLOAD)
   ) classify_i (
      .cmd  (req_cmd),
      .len  (req_len),
      .kind (kind)
   );

   assign is_write = kind == KIND_WRITE;
   assign accept   = (kind == KIND_WRITE) || (kind == KIND_READ);

   aux_hdr_format #(
      .LEN_W (LEN_W),
      .CNT_W (CNT_W)
   ) hdr_i (
      .addr     (req_addr),
      .cmd      (req_cmd),
      .len      (req_len),
      .is_write (is_write),
      .hdr      (hdr),
      .count    (count)
   );

   aux_frame_assemble #(
      .LEN_W       (LEN_W),
      .MAX_PAYLOAD (MAX_PAYLOAD),
      .FRAME_W     (FRAME_W)
   ) frame_i (
      .hdr          (hdr),
      .payload      (req_payload),
      .len          (req_len),
      .emit         (accept),
      .keep_payload (is_write),
      .frame        (frame)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid   <= 1'b0;
         tx_data    <= '0;
         tx_count   <= '0;
         tx_err_len <= 1'b0;
         tx_err_cmd <= 1'b0;
      end else begin
         tx_valid <= req_valid;
         if (req_valid) begin
            tx_data    <= frame;
            tx_count   <= accept ? count : '0;
            tx_err_len <= kind == KIND_BAD_LEN;
            tx_err_cmd <= kind == KIND_BAD_CMD;
         end
      end
   end

   aux_reply_decode #(
      .RX_W (RX_W)
   ) reply_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap_valid    (req_valid && accept),
      .cap_write    (is_write),
      .cap_len      (RX_W'(req_len)),
      .rsp_valid    (rsp_valid),
      .rsp_status   (rsp_status),
      .rsp_rx_len   (rsp_rx_len),
      .rsp_buf_size (rsp_buf_size),
      .rep_valid    (rep_valid),
      .rep_code     (rep_code),
      .rep_timeout  (rep_timeout),
      .rep_flags    (rep_flags),
      .rep_error    (rep_error),
      .rep_len      (rep_len)
   );

   // R6 and R8: a rejected request emits nothing
   p_reject_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && (tx_err_len || tx_err_cmd)) |-> (tx_count == '0 && tx_data == '0));

   // R8: the two rejection reasons never coincide
   p_err_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !(tx_err_len && tx_err_cmd));

   // R1: the low address bytes lead an accepted frame
   p_hdr_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_err_len && !tx_err_cmd) |-> (tx_data[15:0] == $past(req_addr[15:0])));

   // R7: no accepted frame carries more than the write cap beyond the header
   p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_err_len && !tx_err_cmd) |-> (tx_count <= CNT_W'(HDR_BYTES + MAX_WR_PAYLOAD)));

   // R9: the frame strobe follows exactly one request strobe
   p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(req_valid));

endmodule

// File: tb/aux_req_packer_tb_top.sv
module aux_req_packer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [19:0]  req_addr = '0;
   logic [3:0]   req_cmd = '0;
   logic [5:0]   req_len = '0;
   logic [127:0] req_payload = '0;
   logic         tx_valid;
   logic [159:0] tx_data;
   logic [4:0]   tx_count;
   logic         tx_err_len;
   logic         tx_err_cmd;
   logic         rsp_valid = 1'b0;
   logic [7:0]   rsp_status = '0;
   logic [4:0]   rsp_rx_len = '0;
   logic [4:0]   rsp_buf_size = '0;
   logic         rep_valid;
   logic [3:0]   rep_code;
   logic         rep_timeout;
   logic         rep_flags;
   logic         rep_error;
   logic [4:0]   rep_len;

   int checks = 0;
   int failures = 0;

   logic       mdl_wr = 1'b0;
   logic [4:0] mdl_len = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aux_req_packer dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_cmd(req_cmd), .req_len(req_len), .req_payload(req_payload),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_count(tx_count),
      .tx_err_len(tx_err_len), .tx_err_cmd(tx_err_cmd),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rx_len(rsp_rx_len),
      .rsp_buf_size(rsp_buf_size), .rep_valid(rep_valid), .rep_code(rep_code),
      .rep_timeout(rep_timeout), .rep_flags(rep_flags), .rep_error(rep_error),
      .rep_len(rep_len)
   );

   task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // 0 write, 1 read, 2 length reject, 3 command reject
   function automatic logic [1:0] exp_class(input logic [3:0] c, input logic [5:0] l);
      logic [3:0] b;
      logic wr, rd;
      b  = c & 4'hB;
      wr = (b == 4'h0) || (b == 4'h8);
      rd = (b == 4'h1) || (b == 4'h9);
      if (l > 6'd16 || (wr && l > 6'd12)) return 2'd2;
      if (!wr && !rd) return 2'd3;
      return wr ? 2'd0 : 2'd1;
   endfunction

   function automatic logic [159:0] exp_frame(input logic [19:0] a, input logic [3:0] c,
                                              input logic [5:0] l, input logic [127:0] p);
      logic [159:0] f;
      logic [1:0]   k;
      logic [6:0]   cnt;
      logic [3:0]   lo, hi;
      f = '0;
      k = exp_class(c, l);
      if (k >= 2'd2) return f;
      cnt = (k == 2'd0) ? 7'd4 + 7'(l) : 7'd4;
      lo  = (l == 6'd0) ? 4'd0 : 4'(l - 6'd1);
      hi  = (l == 6'd0) ? 4'd3 : cnt[3:0];
      f[7:0]   = a[7:0];
      f[15:8]  = a[15:8];
      f[23:16] = {c, a[19:16]};
      f[31:24] = {hi, lo};
      if (k == 2'd0)
         for (int i = 0; i < 16; i++)
            if (i < int'(l)) f[32+8*i +: 8] = p[8*i +: 8];
      return f;
   endfunction

   task automatic do_req(input logic [19:0] a, input logic [3:0] c,
                         input logic [5:0] l, input logic [127:0] p);
      logic [1:0]   k;
      logic [159:0] ef;
      logic [4:0]   ec;
      k  = exp_class(c, l);
      ef = exp_frame(a, c, l, p);
      ec = (k == 2'd0) ? 5'd4 + 5'(l) : ((k == 2'd1) ? 5'd4 : 5'd0);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_cmd = c; req_len = l; req_payload = p;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", 160'(tx_valid), 160'(1'b1));
      if (k < 2'd2) begin
         chk("R1", 160'(tx_data[15:0]), 160'(ef[15:0]));
         chk("R2", 160'(tx_data[23:16]), 160'(ef[23:16]));
         chk("R3", 160'(tx_data[27:24]), 160'(ef[27:24]));
         chk("R4", 160'(tx_data[31:28]), 160'(ef[31:28]));
         chk("R5", 160'(tx_count), 160'(ec));
         chk("R5", 160'(tx_data[159:32]), 160'(ef[159:32]));
         chk("R8", 160'({tx_err_len, tx_err_cmd}), 160'(2'b00));
         mdl_wr  = (k == 2'd0);
         mdl_len = 5'(l);
      end else if (k == 2'd2) begin
         if (l > 6'd16) begin
            chk("R6", 160'({tx_err_len, tx_err_cmd}), 160'(2'b10));
            chk("R6", tx_data, '0);
            chk("R6", 160'(tx_count), '0);
         end else begin
            chk("R7", 160'({tx_err_len, tx_err_cmd}), 160'(2'b10));
            chk("R7", tx_data, '0);
            chk("R7", 160'(tx_count), '0);
         end
      end else begin
         chk("R8", 160'({tx_err_len, tx_err_cmd}), 160'(2'b01));
         chk("R8", tx_data, '0);
         chk("R8", 160'(tx_count), '0);
      end
      @(negedge clk);
      chk("R9", 160'(tx_valid), 160'(1'b0));
   endtask

   task automatic do_rsp(input logic [7:0] s, input logic [4:0] rx, input logic [4:0] bs);
      logic [2:0] ef;
      logic [3:0] ecode;
      logic [4:0] elen;
      ef    = {s == 8'd1, s == 8'd2, s == 8'd3};
      ecode = (ef != 3'b000) ? 4'd0 : s[7:4];
      elen  = (ef != 3'b000) ? 5'd0 : (mdl_wr ? mdl_len : ((rx > bs) ? bs : rx));
      @(negedge clk);
      rsp_valid = 1'b1; rsp_status = s; rsp_rx_len = rx; rsp_buf_size = bs;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R10", 160'({rep_valid, rep_timeout, rep_flags, rep_error}), 160'({1'b1, ef}));
      if (ef != 3'b000) begin
         chk("R10", 160'({rep_code, rep_len}), 160'({ecode, elen}));
      end else begin
         chk("R11", 160'(rep_code), 160'(ecode));
         if (mdl_wr) chk("R13", 160'(rep_len), 160'(elen));
         else        chk("R12", 160'(rep_len), 160'(elen));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int unsigned seed_tap;
      seed_tap = $urandom(32'd51966);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", 160'({tx_valid, rep_valid}), '0);
      chk("R9", 160'({tx_count, rep_len}), '0);

      // directed corners
      do_req(20'hABCDE, 4'h8, 6'd0, 128'h0);              // bare write, nibble 3
      do_rsp(8'h00, 5'd9, 5'd2);                          // R13 length 0
      do_req(20'h12345, 4'h8, 6'd12, {8{16'hA55A}});      // 12-byte write wraps nibble
      do_rsp(8'h20, 5'd0, 5'd0);                          // R11 code 2, R13 length 12
      do_rsp(8'd1, 5'd3, 5'd3);
      do_rsp(8'd2, 5'd3, 5'd3);
      do_rsp(8'd3, 5'd3, 5'd3);
      do_req(20'h00001, 4'h0, 6'd13, {16{8'h77}});        // R7 write too long
      do_rsp(8'h00, 5'd1, 5'd1);                          // R13 still 12
      do_req(20'hF0F0F, 4'h9, 6'd16, {16{8'hEE}});        // R7 read of 16 accepted
      do_rsp(8'h00, 5'd10, 5'd4);                         // R12 clamp to 4
      do_rsp(8'h10, 5'd3, 5'd16);                         // R12 keep 3
      do_req(20'h00002, 4'h9, 6'd17, 128'h0);             // R6
      do_req(20'h00003, 4'h2, 6'd17, 128'h0);             // R6 over invalid command
      do_req(20'h54321, 4'hC, 6'd2, 128'hBEEF);           // R8 masked native write
      do_req(20'h54321, 4'h5, 6'd0, 128'h0);              // R8 masked I2C read, bare
      do_req(20'h11111, 4'h2, 6'd1, 128'h0);              // R8 invalid
      do_req(20'h22222, 4'hA, 6'd4, 128'h0);              // R8 invalid
      do_rsp(8'hF0, 5'd7, 5'd8);                          // R12 after bare read kind

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] st;
         do_req(20'($urandom), 4'($urandom), 6'($urandom_range(0, 20)),
                {$urandom, $urandom, $urandom, $urandom});
         case ($urandom_range(0, 5))
            0: st = 8'd1;
            1: st = 8'd2;
            2: st = 8'd3;
            default: st = 8'($urandom);
         endcase
         do_rsp(st, 5'($urandom_range(0, 16)), 5'($urandom_range(0, 16)));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule